// File: doc/BRIEF.md
# Auxiliary Power and System Control Register Block

This block is a small memory-mapped register unit that sits beside a workstation I/O controller. It keeps a handful of control bytes (configuration, diagnostic, modem control, miscellaneous functions and software power-down), a 16-bit LED register and a 32-bit system control register. It also turns some register writes into one-clock command pulses: a floppy terminal-count strobe, a power-off request and a system reset request.

The block has one power-failing input. When this input changes and the configuration register allows power-fail interrupts, a sticky status flag is set in the power-down register. The interrupt output stays high while that flag and the enable are both set. Software clears the flag by writing a clear command to the power-down register.

Access is over a single-cycle register bus. Each access carries a register select and an access size. Writes take effect on the clock edge. Read data is combinational while the read is presented. Each register accepts only its own access size.

Top module: `auxctl_regs`

## Requirements
- R1: A reset clears the configuration, modem control, miscellaneous-functions and power-down registers and keeps the interrupt and all three pulse outputs low. Reset is synchronous and active low.
- R2: A reset leaves the diagnostic, LED and system control registers holding their earlier values.
- R3: The configuration (select 0), diagnostic (select 1) and modem control (select 2) registers store the low byte of a byte-sized write (size code 0). They read it back with bus bits 31:8 at zero.
- R4: An access whose size code does not match the selected register, or that uses select 7, writes nothing and reads as zero. Bytes use size code 0, the LED register uses 1 and system control uses 2.
- R5: The interrupt output is high exactly when power-down bit 5 (status) and configuration bit 3 (enable) are both set in the stored registers.
- R6: In a cycle where the power-failing input differs from its value in the previous cycle, the status bit becomes the new input value ANDed with the configuration enable bit 3. In other cycles the status bit keeps its value.
- R7: A power-down write (select 4) without bit 1 stores write bit 0 in bit 0 and the current status in bit 5. All other bits are stored as zero.
- R8: A power-down write with bit 1 set clears the whole register, including the status, so the interrupt drops on the next cycle.
- R9: A power-down write with bit 0 set gives a power-off pulse that is high for exactly the one cycle after the write. This happens whether or not bit 1 is also set.
- R10: A miscellaneous-functions write (select 3) with bit 1 set gives a one-cycle terminal-count pulse in the next cycle. Bit 1 is never stored, and bits 7:2 and 0 are stored.
- R11: A system control write (select 6, size 2) with bit 0 set loads 0x00000002 and gives a one-cycle reset-request pulse in the next cycle. A write with bit 0 clear changes nothing. Reads return the stored value.
- R12: The LED register (select 5, size 1) stores bits 15:0 of a write and reads them back with bits 31:16 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 3 | Register select (0..6, 7 = unused) |
| bus_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no valid read |
| pwr_failing | input | 1 | Power-failing indication |
| pf_irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | Floppy terminal-count pulse |
| poweroff_req | output | 1 | Power-off request pulse |
| sysreset_req | output | 1 | System reset request pulse |

## Verification
The assertions check four things on every cycle. Each of the three pulses follows the matching write in the cycle before. At most one pulse is high at a time. Mismatched-size reads return zero. The interrupt is low after reset and after a clear command. The bench's scenarios cover what cannot be seen from port history alone: the sticky status following input changes under the enable, the merge of status into power-down writes, what survives a reset, and the read-back of every register. A reference model in the bench tracks these values through directed cases and a random mix of writes, reads and input toggles.

// File: rtl/auxctl_pkg.sv
// Package: shared select/size encodings and control-bit positions for the
// auxiliary control register block. Assumes a single 32-bit data bus.
package auxctl_pkg;

    typedef enum logic [2:0] {
        SEL_CFG   = 3'd0,
        SEL_DIAG  = 3'd1,
        SEL_MODEM = 3'd2,
        SEL_MISC  = 3'd3,
        SEL_PDN   = 3'd4,
        SEL_LED   = 3'd5,
        SEL_SYSC  = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int NUM_REGS      = 7;
    localparam int CFG_PFEN_BIT  = 3;
    localparam int PDN_OFF_BIT   = 0;
    localparam int PDN_CLR_BIT   = 1;
    localparam int PDN_STAT_BIT  = 5;
    localparam int MISC_TC_BIT   = 1;
    localparam int SYSC_GO_BIT   = 0;
    localparam int SYSC_STAT_BIT = 1;

    // Access size each register accepts.
    function automatic acc_size_e size_for(input reg_sel_e sel);
        case (sel)
            SEL_LED:  size_for = SZ_HALF;
            SEL_SYSC: size_for = SZ_WORD;
            SEL_NONE: size_for = SZ_RSVD;
            default:  size_for = SZ_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/auxctl_decode.sv
// Access decoder: checks the access size against the selected register and
// produces one-hot write strobes plus a read-valid flag. Assumes one access
// per cycle; select 7 never hits.
module auxctl_decode
    import auxctl_pkg::*;
(
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [2:0]          bus_sel,
    input  logic [1:0]          bus_size,
    output logic [NUM_REGS-1:0] wr_stb,
    output logic                rd_ok
);

    reg_sel_e  sel;
    acc_size_e sz;
    logic      size_ok;

    // Decode select and size into a legality flag.
    always_comb begin
        sel     = reg_sel_e'(bus_sel);
        sz      = acc_size_e'(bus_size);
        size_ok = (sel != SEL_NONE) && (sz == size_for(sel));
    end

    // Write strobes, one per register slot.
    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_stb
            assign wr_stb[i] = bus_en && bus_we && size_ok && (bus_sel == i[2:0]);
        end
    endgenerate

    // Read is valid only with the matching size.
    assign rd_ok = bus_en && !bus_we && size_ok;

endmodule

// File: rtl/auxctl_store.sv
// Generic storage register with a write enable. CLR_ON_RST picks whether
// synchronous reset clears it or leaves its contents alone.
module auxctl_store #(
    parameter int W          = 8,
    parameter bit CLR_ON_RST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (CLR_ON_RST) begin : g_clr
            // Clearable storage.
            always_ff @(posedge clk) begin
                if (!rst_n)  q <= '0;
                else if (we) q <= d;
            end
        end else begin : g_keep
            logic unused_rst;
            assign unused_rst = rst_n;
            // Storage that keeps its value through reset.
            always_ff @(posedge clk) begin
                if (we) q <= d;
            end
        end
    endgenerate

endmodule

// File: rtl/auxctl_pwrfail.sv
// Power-fail logic: tracks changes of the power-failing input, keeps the
// sticky status bit inside the power-down register, handles power-down
// writes (clear command wins over a same-cycle input change) and issues
// the power-off pulse. Assumes the input is already synchronous to clk.
module auxctl_pwrfail
    import auxctl_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_in,
    input  logic              pf_en,
    input  logic              pdn_we,
    input  logic              pdn_off,
    input  logic              pdn_clr,
    output logic [BYTE_W-1:0] pdn_q,
    output logic              irq,
    output logic              off_pulse
);

    logic              pf_prev;
    logic              pf_evt;
    logic              stat_nxt;
    logic [BYTE_W-1:0] wr_val;

    // Remember the input from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pf_prev <= 1'b0;
        else        pf_prev <= pf_in;
    end

    // New status: re-evaluated on an input change, otherwise held.
    always_comb begin
        pf_evt   = pf_in ^ pf_prev;
        stat_nxt = pf_evt ? (pf_in & pf_en) : pdn_q[PDN_STAT_BIT];
        wr_val   = '0;
        wr_val[PDN_OFF_BIT]  = pdn_off;
        wr_val[PDN_STAT_BIT] = stat_nxt;
    end

    // Power-down register with merge-on-write and clear command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdn_q <= '0;
        end else if (pdn_we) begin
            pdn_q <= pdn_clr ? '0 : wr_val;
        end else begin
            pdn_q[PDN_STAT_BIT] <= stat_nxt;
        end
    end

    // One-cycle power-off request.
    always_ff @(posedge clk) begin
        if (!rst_n) off_pulse <= 1'b0;
        else        off_pulse <= pdn_we & pdn_off;
    end

    // Interrupt from stored status and enable.
    assign irq = pdn_q[PDN_STAT_BIT] & pf_en;

endmodule

// File: rtl/auxctl_cmd.sv
// Command registers: miscellaneous-functions byte (terminal-count bit is
// strobed, not stored) and the system control word (go bit loads the
// reset-status value and strobes a reset request). System control keeps
// its value through reset; pulses clear on reset.
module auxctl_cmd
    import auxctl_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SYS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              misc_we,
    input  logic [BYTE_W-1:0] misc_d,
    input  logic              sysc_we,
    input  logic              sysc_go,
    output logic [BYTE_W-1:0] misc_q,
    output logic [SYS_W-1:0]  sysc_q,
    output logic              tc_pulse,
    output logic              rst_pulse
);

    localparam logic [BYTE_W-1:0] TC_MASK   = BYTE_W'(1) << MISC_TC_BIT;
    localparam logic [SYS_W-1:0]  SYSC_STAT = SYS_W'(1) << SYSC_STAT_BIT;

    // Misc byte keeps everything except the strobe bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       misc_q <= '0;
        else if (misc_we) misc_q <= misc_d & ~TC_MASK;
    end

    // System control loads the reset-status value on a go write.
    always_ff @(posedge clk) begin
        if (sysc_we && sysc_go) sysc_q <= SYSC_STAT;
    end

    // Single-cycle command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_pulse  <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            tc_pulse  <= misc_we & misc_d[MISC_TC_BIT];
            rst_pulse <= sysc_we & sysc_go;
        end
    end

endmodule

// File: rtl/auxctl_regs.sv
// Top of the auxiliary power and system control register block. Decodes
// single-cycle accesses, hosts the plain storage bytes and LED word, the
// power-fail logic and the command registers, and muxes read data.
// Assumes one access per cycle and a synchronous power-failing input.
module auxctl_regs
    import auxctl_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int BYTE_W = 8,
    parameter int LED_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [2:0]       bus_sel,
    input  logic [1:0]       bus_size,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             pwr_failing,
    output logic             pf_irq,
    output logic             tc_pulse,
    output logic             poweroff_req,
    output logic             sysreset_req
);

    localparam int           NUM_PLAIN = 3;
    // Slot i of the plain bytes is cleared by reset when bit i is set.
    localparam logic [NUM_PLAIN-1:0] PLAIN_CLR = 3'b101;

    logic [NUM_REGS-1:0] wr_stb;
    logic                rd_ok;
    logic [BYTE_W-1:0]   plain_q [NUM_PLAIN];
    logic [LED_W-1:0]    led_q;
    logic [BYTE_W-1:0]   pdn_q;
    logic [BYTE_W-1:0]   misc_q;
    logic [BUS_W-1:0]    sysc_q;
    logic                unused_hi;

    assign unused_hi = ^bus_wdata[BUS_W-1:LED_W];

    auxctl_decode u_dec (
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_sel  (bus_sel),
        .bus_size (bus_size),
        .wr_stb   (wr_stb),
        .rd_ok    (rd_ok)
    );

    // Configuration, diagnostic and modem bytes share one storage shape.
    generate
        for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
            auxctl_store #(.W(BYTE_W), .CLR_ON_RST(PLAIN_CLR[i])) u_byte (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (wr_stb[i]),
                .d     (bus_wdata[BYTE_W-1:0]),
                .q     (plain_q[i])
            );
        end
    endgenerate

    auxctl_store #(.W(LED_W), .CLR_ON_RST(1'b0)) u_led (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_stb[SEL_LED]),
        .d     (bus_wdata[LED_W-1:0]),
        .q     (led_q)
    );

    auxctl_pwrfail #(.BYTE_W(BYTE_W)) u_pf (
        .clk       (clk),
        .rst_n     (rst_n),
        .pf_in     (pwr_failing),
        .pf_en     (plain_q[SEL_CFG][CFG_PFEN_BIT]),
        .pdn_we    (wr_stb[SEL_PDN]),
        .pdn_off   (bus_wdata[PDN_OFF_BIT]),
        .pdn_clr   (bus_wdata[PDN_CLR_BIT]),
        .pdn_q     (pdn_q),
        .irq       (pf_irq),
        .off_pulse (poweroff_req)
    );

    auxctl_cmd #(.BYTE_W(BYTE_W), .SYS_W(BUS_W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .misc_we   (wr_stb[SEL_MISC]),
        .misc_d    (bus_wdata[BYTE_W-1:0]),
        .sysc_we   (wr_stb[SEL_SYSC]),
        .sysc_go   (bus_wdata[SYSC_GO_BIT]),
        .misc_q    (misc_q),
        .sysc_q    (sysc_q),
        .tc_pulse  (tc_pulse),
        .rst_pulse (sysreset_req)
    );

    // Read mux: zero unless a correctly sized read is presented.
    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (reg_sel_e'(bus_sel))
                SEL_CFG:   bus_rdata = BUS_W'(plain_q[SEL_CFG]);
                SEL_DIAG:  bus_rdata = BUS_W'(plain_q[SEL_DIAG]);
                SEL_MODEM: bus_rdata = BUS_W'(plain_q[SEL_MODEM]);
                SEL_MISC:  bus_rdata = BUS_W'(misc_q);
                SEL_PDN:   bus_rdata = BUS_W'(pdn_q);
                SEL_LED:   bus_rdata = BUS_W'(led_q);
                SEL_SYSC:  bus_rdata = sysc_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/auxctl_regs_chk.sv
// Checker for auxctl_regs: port-level temporal properties, bound to the top.
module auxctl_regs_chk #(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [2:0]       bus_sel,
    input logic [1:0]       bus_size,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             pf_irq,
    input logic             tc_pulse,
    input logic             poweroff_req,
    input logic             sysreset_req
);

    logic [1:0] need_sz;
    always_comb begin
        case (bus_sel)
            3'd5:    need_sz = 2'd1;
            3'd6:    need_sz = 2'd2;
            3'd7:    need_sz = 2'd3;
            default: need_sz = 2'd0;
        endcase
    end

    // R9: power-off pulse only after a byte write to power-down with bit 0.
    assert_off_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        poweroff_req |-> $past(bus_en && bus_we && bus_sel == 3'd4 &&
                               bus_size == 2'd0 && bus_wdata[0]));

    // R10: terminal-count pulse only after a misc write with bit 1.
    assert_tc_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(bus_en && bus_we && bus_sel == 3'd3 &&
                           bus_size == 2'd0 && bus_wdata[1]));

    // R11: reset request only after a word write to system control with bit 0.
    assert_rst_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sysreset_req |-> $past(bus_en && bus_we && bus_sel == 3'd6 &&
                               bus_size == 2'd2 && bus_wdata[0]));

    // R9/R10/R11: one access per cycle, so at most one pulse.
    assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tc_pulse, poweroff_req, sysreset_req}));

    // R4: mismatched-size reads return zero.
    assert_bad_size_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_size != need_sz) |-> bus_rdata == '0);

    // R8: a clear command drops the interrupt on the next cycle.
    assert_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_sel == 3'd4 && bus_size == 2'd0 && bus_wdata[1])
        |=> !pf_irq);

    // R1: interrupt is low on the first cycle out of reset.
    assert_reset_irq_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pf_irq);

endmodule

bind auxctl_regs auxctl_regs_chk #(.BUS_W(BUS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_en       (bus_en),
    .bus_we       (bus_we),
    .bus_sel      (bus_sel),
    .bus_size     (bus_size),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pf_irq       (pf_irq),
    .tc_pulse     (tc_pulse),
    .poweroff_req (poweroff_req),
    .sysreset_req (sysreset_req)
);

// File: tb/sim_auxctl_regs.sv
module sim_auxctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_sel = 3'd0;
    logic [1:0]  bus_size = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        pwr_failing = 1'b0;
    logic        pf_irq, tc_pulse, poweroff_req, sysreset_req;

    int checks = 0;
    int fails  = 0;

    // Reference model state.
    logic [7:0]  m_cfg, m_diag, m_modem, m_misc, m_pdn;
    logic [15:0] m_led;
    logic [31:0] m_sys;
    logic        m_pfprev;
    logic        e_off = 1'b0, e_tc = 1'b0, e_rst = 1'b0;

    always #10 clk = ~clk;

    auxctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwr_failing(pwr_failing), .pf_irq(pf_irq),
        .tc_pulse(tc_pulse), .poweroff_req(poweroff_req),
        .sysreset_req(sysreset_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] need_size(input logic [2:0] sel);
        if (sel == 3'd5)      return 2'd1;
        else if (sel == 3'd6) return 2'd2;
        else if (sel == 3'd7) return 2'd3;
        else                  return 2'd0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] sel, input logic [1:0] sz);
        if (sel == 3'd7 || sz != need_size(sel)) return 32'd0;
        case (sel)
            3'd0: return {24'd0, m_cfg};
            3'd1: return {24'd0, m_diag};
            3'd2: return {24'd0, m_modem};
            3'd3: return {24'd0, m_misc};
            3'd4: return {24'd0, m_pdn};
            3'd5: return {16'd0, m_led};
            default: return m_sys;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] sel, input logic [1:0] sz);
        if (sel == 3'd7 || sz != need_size(sel)) return "R4";
        case (sel)
            3'd3: return "R10";
            3'd4: return "R7";
            3'd5: return "R12";
            3'd6: return "R11";
            default: return "R3";
        endcase
    endfunction

    // One bus cycle, entered and left at a falling edge.
    task automatic step(input logic en, input logic we, input logic [2:0] sel,
                        input logic [1:0] sz, input logic [31:0] wd, input logic pf,
                        input string xtag = "", input logic [31:0] xexp = 32'd0);
        logic ok, evt, stat;
        chk("R9",  {31'd0, poweroff_req}, {31'd0, e_off});
        chk("R10", {31'd0, tc_pulse},     {31'd0, e_tc});
        chk("R11", {31'd0, sysreset_req}, {31'd0, e_rst});
        chk("R5",  {31'd0, pf_irq},       {31'd0, m_pdn[5] & m_cfg[3]});
        bus_en = en; bus_we = we; bus_sel = sel; bus_size = sz;
        bus_wdata = wd; pwr_failing = pf;
        #2;
        if (en && !we) begin
            chk(tag_of(sel, sz), bus_rdata, exp_read(sel, sz));
            if (xtag != "") chk(xtag, bus_rdata, xexp);
        end
        ok   = en && we && sel != 3'd7 && sz == need_size(sel);
        evt  = (pf != m_pfprev);
        stat = evt ? (pf & m_cfg[3]) : m_pdn[5];
        m_pfprev = pf;
        e_off = 1'b0; e_tc = 1'b0; e_rst = 1'b0;
        if (ok && sel == 3'd4) begin
            m_pdn = wd[1] ? 8'd0 : {2'b00, stat, 4'b0000, wd[0]};
            e_off = wd[0];
        end else begin
            m_pdn[5] = stat;
        end
        if (ok) begin
            case (sel)
                3'd0: m_cfg   = wd[7:0];
                3'd1: m_diag  = wd[7:0];
                3'd2: m_modem = wd[7:0];
                3'd3: begin m_misc = wd[7:0] & 8'hFD; e_tc = wd[1]; end
                3'd5: m_led   = wd[15:0];
                3'd6: if (wd[0]) begin m_sys = 32'h2; e_rst = 1'b1; end
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        bus_en = 1'b0; bus_we = 1'b0;
        rst_n = 1'b0;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        rst_n = 1'b1;
        m_cfg = 8'd0; m_modem = 8'd0; m_misc = 8'd0; m_pdn = 8'd0;
        m_pfprev = 1'b0;
        e_off = 1'b0; e_tc = 1'b0; e_rst = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic pf_cur;
        void'($urandom(32'h1A2B3C));
        @(negedge clk);
        do_reset();
        // R1: cleared registers after reset.
        step(1, 0, 3'd0, 2'd0, 0, 0, "R1", 32'd0);
        step(1, 0, 3'd2, 2'd0, 0, 0, "R1", 32'd0);
        step(1, 0, 3'd3, 2'd0, 0, 0, "R1", 32'd0);
        step(1, 0, 3'd4, 2'd0, 0, 0, "R1", 32'd0);
        // Load retained registers.
        step(1, 1, 3'd1, 2'd0, 32'hFFFF_FFA5, 0);
        step(1, 1, 3'd5, 2'd1, 32'h1234_BEEF, 0);
        step(1, 1, 3'd6, 2'd2, 32'hFFFF_FFFF, 0);
        step(1, 0, 3'd6, 2'd2, 0, 0, "R11", 32'h2);
        step(1, 1, 3'd6, 2'd2, 32'h0000_0004, 0);
        step(1, 0, 3'd6, 2'd2, 0, 0, "R11", 32'h2);
        step(1, 0, 3'd1, 2'd0, 0, 0, "R3", 32'hA5);
        step(1, 0, 3'd5, 2'd1, 0, 0, "R12", 32'hBEEF);
        // R6: enabled input change sets status; R5 interrupt follows.
        step(1, 1, 3'd0, 2'd0, 32'h08, 0);
        step(1, 0, 3'd4, 2'd0, 0, 1);
        step(1, 0, 3'd4, 2'd0, 0, 1, "R6", 32'h20);
        // R7/R9: merge of status with power-off bit.
        step(1, 1, 3'd4, 2'd0, 32'hF9, 1);
        step(1, 0, 3'd4, 2'd0, 0, 1, "R7", 32'h21);
        // R8: clear command drops the status.
        step(1, 1, 3'd4, 2'd0, 32'h02, 1);
        step(1, 0, 3'd4, 2'd0, 0, 1, "R8", 32'h00);
        // R6: disabled input change leaves status clear.
        step(1, 1, 3'd0, 2'd0, 32'h00, 1);
        step(1, 0, 3'd4, 2'd0, 0, 0);
        step(1, 0, 3'd4, 2'd0, 0, 1, "R6", 32'h00);
        // R10: strobe bit is not stored.
        step(1, 1, 3'd3, 2'd0, 32'hFF, 1);
        step(1, 0, 3'd3, 2'd0, 0, 1, "R10", 32'hFD);
        // R4: wrong-size write ignored and wrong-size read returns zero.
        step(1, 1, 3'd0, 2'd2, 32'h08, 1);
        step(1, 0, 3'd0, 2'd0, 0, 1, "R4", 32'h00);
        step(1, 0, 3'd5, 2'd0, 0, 1, "R4", 32'h00);
        step(1, 0, 3'd7, 2'd0, 0, 1, "R4", 32'h00);
        // R2: retention across reset.
        do_reset();
        step(1, 0, 3'd1, 2'd0, 0, 1, "R2", 32'hA5);
        step(1, 0, 3'd5, 2'd1, 0, 1, "R2", 32'hBEEF);
        step(1, 0, 3'd6, 2'd2, 0, 1, "R2", 32'h2);
        step(1, 0, 3'd0, 2'd0, 0, 1, "R1", 32'h0);
        // Constrained random mix.
        pf_cur = 1'b1;
        for (int i = 0; i < 1500; i++) begin
            logic [2:0] s;
            logic [1:0] z;
            s = 3'($urandom % 8);
            z = ($urandom % 4 != 0) ? need_size(s) : 2'($urandom % 4);
            if ($urandom % 8 == 0) pf_cur = ~pf_cur;
            step(($urandom % 5) != 0, $urandom % 2 == 0, s, z, $urandom, pf_cur);
        end
        step(0, 0, 3'd0, 2'd0, 0, pf_cur);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule